// File: doc/BRIEF.md
# Bus Beat Performance Counter Unit

This block sits next to a bus port and measures traffic on it. One cycle counter and four event counters advance under software control. Each event counter has its own event-type selector, which picks read data beats, write data beats or, for the last counter, both kinds together. The monitored port supplies one-cycle read-beat and write-beat pulses.

Software reaches the unit through a flat 32-bit register interface made of a write strobe, a read strobe, a byte address and write data. Registers sit 4 bytes apart. Address bits [1:0] are ignored, and an address at or above 0x40 hits nothing. Read data is combinational and is zero whenever the read strobe is low.

A typical session follows four steps. Software chooses event types, sets counter enables, and writes the control register with the run bit and both reset bits in one access. To take a measurement it clears the run bit, which freezes every counter so that the values read afterwards form one consistent snapshot. The last event counter is wider than 32 bits and is read as a low and high pair. Each counter sets a sticky wrap flag when it rolls over.

Top module: `pm_unit_top`

## Requirements
- R1: After reset, every register reads as zero: control, enables, flags, counters and event types.
- R2: The enable mask uses bit 31 for the cycle counter and bits 3:0 for event counters 0 to 3. Writing to 0x04 sets the enable bits written as one. Writing to 0x08 clears the enable bits written as one. Bits written as zero leave their enables unchanged. A read of either address returns the current mask.
- R3: Control register 0x00 holds the run bit at bit 0 and the start-mode field at bits 5:4. A counter advances only in a cycle where all of the following are true: the run bit is 1, the mode is manual (00), the counter's own enable bit is set, and, for event counters, the selected event occurs. The cycle counter adds one in each such cycle.
- R4: Writing control bit 1 as one zeroes all four event counters. Writing control bit 2 as one zeroes the cycle counter. Both bits read back as zero. If a reset bit is written in the same access as the run bit, the counters start from zero and advance from the next cycle.
- R5: A write that clears the run bit still allows the counters to advance in that write's own cycle. From the next cycle on, every counter holds its value regardless of beat activity.
- R6: Bits 1:0 of the type register at 0x30+4*i select the event for counter i: 0 selects nothing, 1 selects read beats, 2 selects write beats, 3 selects both. Code 3 counts nothing on counters 0 to 2. On counter 3, code 3 adds 2 when both beats occur in the same cycle.
- R7: The cycle counter reads at 0x10 and event counters 0 to 2 read at 0x14, 0x18 and 0x1C. Counter 3 is 40 bits by default. Address 0x20 returns its bits 31:0, and address 0x24 returns bits 39:32 in bits 7:0, with bits 31:8 zero.
- R8: A counter that rolls past its maximum wraps modulo its width and sets its flag in register 0x0C, using the same bit positions as the enable mask. Writing one to a flag bit clears it. A wrap in the same cycle keeps the flag set.
- R9: A start mode other than 00 stops all counting while the run bit is set.
- R10: Writes to counter addresses and to unmapped addresses change nothing. Reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, zero when reg_rd is low |
| beat_rd | input | 1 | Read data beat seen on the monitored port this cycle |
| beat_wr | input | 1 | Write data beat seen on the monitored port this cycle |

## Verification
Wrapping a counter is the hardest situation to reach, because a 32-bit or 40-bit counter needs billions of events before it rolls over. The bench therefore drives a second instance with 6-bit and 10-bit counters from the same register and beat stream, so that wraps, flag setting and flag clearing happen many times in a short run. The cycle in which a stop write still counts, and a wrap landing together with a flag clear, both come up under a random stream that mixes beats, control writes and enable toggling. A bench model tracks both instances through every one of these cycles.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int NUM_EV      = 4;
  localparam int IDX_W       = 4;
  localparam int CYC_BIT     = 31;
  localparam int CTL_RUN     = 0;
  localparam int CTL_EVRST   = 1;
  localparam int CTL_CYRST   = 2;
  localparam int CTL_MODE_LO = 4;
  localparam logic [1:0] MODE_MANUAL = 2'b00;

  typedef enum logic [1:0] {EVT_NONE = 2'd0, EVT_RD = 2'd1, EVT_WR = 2'd2, EVT_BOTH = 2'd3} evt_e;

  localparam logic [IDX_W-1:0] W_CTRL  = 4'd0;
  localparam logic [IDX_W-1:0] W_ENSET = 4'd1;
  localparam logic [IDX_W-1:0] W_ENCLR = 4'd2;
  localparam logic [IDX_W-1:0] W_FLAG  = 4'd3;
  localparam logic [IDX_W-1:0] W_CYC   = 4'd4;
  localparam logic [IDX_W-1:0] W_EV0   = 4'd5;
  localparam logic [IDX_W-1:0] W_EV1   = 4'd6;
  localparam logic [IDX_W-1:0] W_EV2   = 4'd7;
  localparam logic [IDX_W-1:0] W_EV3L  = 4'd8;
  localparam logic [IDX_W-1:0] W_EV3H  = 4'd9;
endpackage

// File: rtl/pm_counter.sv
module pm_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [1:0]   amt,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W:0]   sum;
  logic         step;

  always_comb begin
    step  = (amt != 2'd0);
    sum   = {1'b0, cnt_q} + {{(W-1){1'b0}}, amt};
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (step) cnt_d = sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clr || step)   cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign wrap = step && !clr && sum[W];

  // R4
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (cnt == '0));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (!clr && amt == 2'd0) |=> $stable(cnt));
  // R8
  wrap_low_chk: assert property (@(posedge clk) disable iff (!rst_n) wrap |=> (cnt < W'(2)));
endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pm_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [31:0]            wdata,
  input  logic                   beat_rd,
  input  logic                   beat_wr,
  input  logic [NUM_EV-1:0]      ev_wrap,
  input  logic                   cyc_wrap,
  output logic                   run,
  output logic                   cyc_amt,
  output logic [NUM_EV-1:0][1:0] ev_amt,
  output logic                   ev_clr,
  output logic                   cyc_clr,
  output logic [31:0]            ctrl_rd,
  output logic [31:0]            en_rd,
  output logic [31:0]            flag_rd,
  output logic [NUM_EV-1:0][1:0] ev_type
);
  logic                   run_q, run_d;
  logic [1:0]             mode_q, mode_d;
  logic [NUM_EV:0]        en_q, en_d;
  logic [NUM_EV:0]        flag_q, flag_d;
  logic [NUM_EV-1:0][1:0] type_q, type_d;
  logic [NUM_EV:0]        wsel;
  logic                   we_ctrl, we_set, we_clr, we_flag, we_type;
  logic                   wdata_unused;

  assign wsel         = {wdata[CYC_BIT], wdata[NUM_EV-1:0]};
  assign wdata_unused = ^{wdata[30:6], wdata[3]};
  assign we_ctrl = wr_en && (wr_idx == W_CTRL);
  assign we_set  = wr_en && (wr_idx == W_ENSET);
  assign we_clr  = wr_en && (wr_idx == W_ENCLR);
  assign we_flag = wr_en && (wr_idx == W_FLAG);
  assign we_type = wr_en && (wr_idx[3:2] == 2'b11);

  always_comb begin
    run_d  = run_q;
    mode_d = mode_q;
    en_d   = en_q;
    type_d = type_q;
    if (we_ctrl) begin
      run_d  = wdata[CTL_RUN];
      mode_d = wdata[CTL_MODE_LO+1:CTL_MODE_LO];
    end
    if (we_set) en_d = en_q | wsel;
    if (we_clr) en_d = en_q & ~wsel;
    if (we_type) type_d[wr_idx[1:0]] = wdata[1:0];
    flag_d = flag_q;
    if (we_flag) flag_d = flag_q & ~wsel;
    flag_d = flag_d | {cyc_wrap, ev_wrap};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mode_q <= MODE_MANUAL;
      en_q   <= '0;
      flag_q <= '0;
      type_q <= '0;
    end else begin
      if (we_ctrl)                 run_q  <= run_d;
      if (we_ctrl)                 mode_q <= mode_d;
      if (we_set || we_clr)        en_q   <= en_d;
      if (we_type)                 type_q <= type_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    run     = run_q && (mode_q == MODE_MANUAL);
    cyc_amt = run && en_q[NUM_EV];
    for (int i = 0; i < NUM_EV; i++) begin
      ev_amt[i] = 2'd0;
      if (run && en_q[i]) begin
        case (evt_e'(type_q[i]))
          EVT_RD:   ev_amt[i] = {1'b0, beat_rd};
          EVT_WR:   ev_amt[i] = {1'b0, beat_wr};
          EVT_BOTH: ev_amt[i] = (i == NUM_EV-1) ? ({1'b0, beat_rd} + {1'b0, beat_wr}) : 2'd0;
          default:  ev_amt[i] = 2'd0;
        endcase
      end
    end
  end

  assign ev_clr  = we_ctrl && wdata[CTL_EVRST];
  assign cyc_clr = we_ctrl && wdata[CTL_CYRST];
  assign ctrl_rd = {26'd0, mode_q, 3'd0, run_q};
  assign en_rd   = {en_q[NUM_EV], 27'd0, en_q[NUM_EV-1:0]};
  assign flag_rd = {flag_q[NUM_EV], 27'd0, flag_q[NUM_EV-1:0]};
  assign ev_type = type_q;

  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_set |=> ((en_q & $past(wsel)) == $past(wsel)));
  // R2
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_clr |=> ((en_q & $past(wsel)) == '0));
  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_wrap |=> flag_q[NUM_EV]);
endmodule

// File: rtl/pm_rdmux.sv
module pm_rdmux
  import pm_pkg::*;
(
  input  logic                   rd_en,
  input  logic [IDX_W-1:0]       idx,
  input  logic [31:0]            ctrl_rd,
  input  logic [31:0]            en_rd,
  input  logic [31:0]            flag_rd,
  input  logic [31:0]            cyc_val,
  input  logic [NUM_EV-1:0][63:0] ev_val,
  input  logic [NUM_EV-1:0][1:0] ev_type,
  output logic [31:0]            rdata
);
  always_comb begin
    rdata = 32'd0;
    if (rd_en) begin
      case (idx)
        W_CTRL:  rdata = ctrl_rd;
        W_ENSET: rdata = en_rd;
        W_ENCLR: rdata = en_rd;
        W_FLAG:  rdata = flag_rd;
        W_CYC:   rdata = cyc_val;
        W_EV0:   rdata = ev_val[0][31:0];
        W_EV1:   rdata = ev_val[1][31:0];
        W_EV2:   rdata = ev_val[2][31:0];
        W_EV3L:  rdata = ev_val[NUM_EV-1][31:0];
        W_EV3H:  rdata = ev_val[NUM_EV-1][63:32];
        default: rdata = (idx[3:2] == 2'b11) ? {30'd0, ev_type[idx[1:0]]} : 32'd0;
      endcase
    end
  end
endmodule

// File: rtl/pm_unit_top.sv
module pm_unit_top
  import pm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CYC_W  = 32,
  parameter int EV_W   = 32,
  parameter int EV3_W  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              beat_rd,
  input  logic              beat_wr
);
  localparam int MAP_W = IDX_W + 2;

  logic [1:0]             rst_sync_q;
  logic                   rst_int_n;
  logic                   hit;
  logic [IDX_W-1:0]       idx;
  logic                   addr_unused;
  logic                   run, cyc_amt, ev_clr, cyc_clr, cyc_wrap;
  logic [NUM_EV-1:0][1:0] ev_amt, ev_type;
  logic [NUM_EV-1:0]      ev_wrap;
  logic [NUM_EV-1:0][63:0] ev_val;
  logic [31:0]            ctrl_rd, en_rd, flag_rd;
  logic [CYC_W-1:0]       cyc_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign hit         = (reg_addr[ADDR_W-1:MAP_W] == '0);
  assign idx         = reg_addr[MAP_W-1:2];
  assign addr_unused = ^reg_addr[1:0];

  pm_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .wr_en(reg_wr && hit), .wr_idx(idx), .wdata(reg_wdata),
    .beat_rd(beat_rd), .beat_wr(beat_wr), .ev_wrap(ev_wrap), .cyc_wrap(cyc_wrap),
    .run(run), .cyc_amt(cyc_amt), .ev_amt(ev_amt), .ev_clr(ev_clr), .cyc_clr(cyc_clr),
    .ctrl_rd(ctrl_rd), .en_rd(en_rd), .flag_rd(flag_rd), .ev_type(ev_type)
  );

  pm_counter #(.W(CYC_W)) u_cyc (
    .clk(clk), .rst_n(rst_int_n), .clr(cyc_clr), .amt({1'b0, cyc_amt}),
    .cnt(cyc_cnt), .wrap(cyc_wrap)
  );

  for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
    localparam int CW = (g == NUM_EV-1) ? EV3_W : EV_W;
    logic [CW-1:0] cnt;
    pm_counter #(.W(CW)) u_cnt (
      .clk(clk), .rst_n(rst_int_n), .clr(ev_clr), .amt(ev_amt[g]),
      .cnt(cnt), .wrap(ev_wrap[g])
    );
    assign ev_val[g] = 64'(cnt);
  end

  pm_rdmux u_rd (
    .rd_en(reg_rd && hit), .idx(idx), .ctrl_rd(ctrl_rd), .en_rd(en_rd), .flag_rd(flag_rd),
    .cyc_val(32'(cyc_cnt)), .ev_val(ev_val), .ev_type(ev_type), .rdata(reg_rdata)
  );

  // R5
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!run && !cyc_clr && !ev_clr) |=> ($stable(cyc_cnt) && $stable(ev_val)));
endmodule

// File: tb/sim_pm_unit_top.sv
module sim_pm_unit_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0, beat_rd = 1'b0, beat_wr = 1'b0;
  logic [7:0]  reg_addr = 8'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] rdata0, rdata1;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pm_unit_top u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata0), .beat_rd(beat_rd), .beat_wr(beat_wr));
  pm_unit_top #(.CYC_W(6), .EV_W(6), .EV3_W(10)) u1 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata1),
    .beat_rd(beat_rd), .beat_wr(beat_wr));

  // bench model of both instances
  logic [63:0] m_cyc [2];
  logic [63:0] m_ev  [2][4];
  logic [4:0]  m_flag[2];
  logic        m_run;
  logic [1:0]  m_mode;
  logic [4:0]  m_en;
  logic [1:0]  m_type[4];

  function automatic logic [63:0] msk(input int w);
    return (64'd1 << w) - 64'd1;
  endfunction
  function automatic int cw(input int k);
    return (k == 0) ? 32 : 6;
  endfunction
  function automatic int ew(input int k, input int i);
    if (i == 3) return (k == 0) ? 40 : 10;
    return (k == 0) ? 32 : 6;
  endfunction

  always @(posedge clk) begin : model
    logic run, evc, cyc_c;
    logic [4:0]  wrapv, sel;
    logic [63:0] nv;
    logic [1:0]  amt;
    if (!rst_n) begin
      m_run = 1'b0; m_mode = 2'd0; m_en = 5'd0;
      for (int k = 0; k < 2; k++) begin
        m_cyc[k] = 64'd0; m_flag[k] = 5'd0;
        for (int i = 0; i < 4; i++) m_ev[k][i] = 64'd0;
      end
      for (int i = 0; i < 4; i++) m_type[i] = 2'd0;
    end else begin
      run   = m_run && (m_mode == 2'd0);
      evc   = reg_wr && reg_addr == 8'h00 && reg_wdata[1];
      cyc_c = reg_wr && reg_addr == 8'h00 && reg_wdata[2];
      sel   = {reg_wdata[31], reg_wdata[3:0]};
      for (int k = 0; k < 2; k++) begin
        wrapv = 5'd0;
        if (cyc_c) m_cyc[k] = 64'd0;
        else if (run && m_en[4]) begin
          nv = m_cyc[k] + 64'd1;
          if (nv > msk(cw(k))) begin wrapv[4] = 1'b1; nv = nv & msk(cw(k)); end
          m_cyc[k] = nv;
        end
        for (int i = 0; i < 4; i++) begin
          amt = 2'd0;
          if (run && m_en[i]) begin
            case (m_type[i])
              2'd1: amt = {1'b0, beat_rd};
              2'd2: amt = {1'b0, beat_wr};
              2'd3: amt = (i == 3) ? ({1'b0, beat_rd} + {1'b0, beat_wr}) : 2'd0;
              default: amt = 2'd0;
            endcase
          end
          if (evc) m_ev[k][i] = 64'd0;
          else if (amt != 2'd0) begin
            nv = m_ev[k][i] + 64'(amt);
            if (nv > msk(ew(k, i))) begin wrapv[i] = 1'b1; nv = nv & msk(ew(k, i)); end
            m_ev[k][i] = nv;
          end
        end
        if (reg_wr && reg_addr == 8'h0C) m_flag[k] = m_flag[k] & ~sel;
        m_flag[k] = m_flag[k] | wrapv;
      end
      if (reg_wr) begin
        case (reg_addr)
          8'h00: begin m_run = reg_wdata[0]; m_mode = reg_wdata[5:4]; end
          8'h04: m_en = m_en | sel;
          8'h08: m_en = m_en & ~sel;
          8'h30: m_type[0] = reg_wdata[1:0];
          8'h34: m_type[1] = reg_wdata[1:0];
          8'h38: m_type[2] = reg_wdata[1:0];
          8'h3C: m_type[3] = reg_wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] exp_read(input int k, input logic [7:0] a);
    case (a)
      8'h00: return {26'd0, m_mode, 3'd0, m_run};
      8'h04, 8'h08: return {m_en[4], 27'd0, m_en[3:0]};
      8'h0C: return {m_flag[k][4], 27'd0, m_flag[k][3:0]};
      8'h10: return m_cyc[k][31:0];
      8'h14: return m_ev[k][0][31:0];
      8'h18: return m_ev[k][1][31:0];
      8'h1C: return m_ev[k][2][31:0];
      8'h20: return m_ev[k][3][31:0];
      8'h24: return m_ev[k][3][63:32];
      8'h30: return {30'd0, m_type[0]};
      8'h34: return {30'd0, m_type[1]};
      8'h38: return {30'd0, m_type[2]};
      8'h3C: return {30'd0, m_type[3]};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic step(input bit w, input bit r, input logic [7:0] a, input logic [31:0] d,
                      input bit br, input bit bw);
    @(negedge clk);
    reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d; beat_rd = br; beat_wr = bw;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(1'b1, 1'b0, a, d, 1'b0, 1'b0);
  endtask

  task automatic rd(input logic [7:0] a, input string tag, output logic [31:0] v0, output logic [31:0] v1);
    step(1'b0, 1'b1, a, 32'd0, 1'b0, 1'b0);
    #1;
    v0 = rdata0; v1 = rdata1;
    chk({tag, " model u0"}, v0, exp_read(0, a));
    chk({tag, " model u1"}, v1, exp_read(1, a));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] v0, v1;
    int r;
    logic [7:0] a;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 16; i++) begin
      rd(8'(i * 4), "R1", v0, v1);
      chk("R1 zero u0", v0, 32'd0);
    end

    // R2 set/clear enables
    wr(8'h04, 32'h8000_0005);
    rd(8'h04, "R2", v0, v1); chk("R2 set", v0, 32'h8000_0005);
    wr(8'h08, 32'h0000_0004);
    rd(8'h08, "R2", v0, v1); chk("R2 clear", v0, 32'h8000_0001);
    wr(8'h04, 32'h0);
    rd(8'h04, "R2", v0, v1); chk("R2 zero bits", v0, 32'h8000_0001);

    // R6 types, R4 reset with run, R3 counting
    wr(8'h30, 32'd1); wr(8'h34, 32'd2); wr(8'h38, 32'd3); wr(8'h3C, 32'd3);
    wr(8'h04, 32'h8000_000F);
    wr(8'h00, 32'h7);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 8'h00, 32'd0, 1'b1, 1'b1);
    wr(8'h00, 32'h0);
    rd(8'h10, "R3", v0, v1); chk("R3 cycle u0", v0, 32'd11); chk("R3 cycle u1", v1, 32'd11);
    rd(8'h14, "R6", v0, v1); chk("R6 read beats", v0, 32'd10);
    rd(8'h18, "R6", v0, v1); chk("R6 write beats", v0, 32'd10);
    rd(8'h1C, "R6", v0, v1); chk("R6 code3 on ctr2", v0, 32'd0);
    rd(8'h20, "R6", v0, v1); chk("R6 both on ctr3", v0, 32'd20);
    rd(8'h24, "R7", v0, v1); chk("R7 high", v0, 32'd0);
    rd(8'h00, "R4", v0, v1); chk("R4 reset bits read 0", v0, 32'd0);
    // R5 freeze
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 8'h00, 32'd0, 1'b1, 1'b1);
    rd(8'h10, "R5", v0, v1); chk("R5 frozen cycle", v0, 32'd11);
    rd(8'h20, "R5", v0, v1); chk("R5 frozen ctr3", v0, 32'd20);

    // R9 non-manual mode
    wr(8'h00, 32'h17);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 8'h00, 32'd0, 1'b1, 1'b1);
    rd(8'h10, "R9", v0, v1); chk("R9 no count", v0, 32'd0);
    rd(8'h14, "R9", v0, v1); chk("R9 no events", v0, 32'd0);

    // R8 wrap on small instance
    wr(8'h00, 32'h5);
    for (int i = 0; i < 70; i++) step(1'b0, 1'b0, 8'h00, 32'd0, 1'b0, 1'b0);
    wr(8'h00, 32'h0);
    rd(8'h10, "R8", v0, v1); chk("R8 cycle u0", v0, 32'd71); chk("R8 wrapped u1", v1, 32'd7);
    rd(8'h0C, "R8", v0, v1); chk("R8 flag u0", v0, 32'd0); chk("R8 flag u1", v1, 32'h8000_0000);
    wr(8'h0C, 32'h8000_0000);
    rd(8'h0C, "R8", v0, v1); chk("R8 w1c", v1, 32'd0);

    // R10 read-only and unmapped
    wr(8'h10, 32'hDEAD_BEEF);
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h10, "R10", v0, v1); chk("R10 ro write", v0, 32'd71);
    rd(8'h28, "R10", v0, v1); chk("R10 unmapped", v0, 32'd0);
    step(1'b0, 1'b0, 8'h10, 32'd0, 1'b0, 1'b0);
    #1; chk("R10 idle rdata", rdata0, 32'd0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      r = $urandom_range(0, 99);
      if (r < 60) step(1'b0, 1'b0, 8'h00, 32'd0, 1'($urandom), 1'($urandom));
      else if (r < 75) begin
        a = 8'($urandom_range(0, 15) * 4);
        rd(a, "R3 random", v0, v1);
      end else if (r < 80) begin
        step(1'b1, 1'b0, 8'h00,
             {26'd0, ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'd0, 1'b0,
              ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0), ($urandom_range(0, 3) != 0)},
             1'($urandom), 1'($urandom));
      end else if (r < 88)
        step(1'b1, 1'b0, ($urandom_range(0, 2) == 0) ? 8'h08 : 8'h04, $urandom, 1'($urandom), 1'($urandom));
      else if (r < 92)
        step(1'b1, 1'b0, 8'h0C, $urandom, 1'($urandom), 1'($urandom));
      else if (r < 97)
        step(1'b1, 1'b0, 8'(8'h30 + $urandom_range(0, 3) * 4), $urandom, 1'($urandom), 1'($urandom));
      else
        step(1'b1, 1'b0, 8'(8'h10 + $urandom_range(0, 6) * 4), $urandom, 1'($urandom), 1'($urandom));
    end
    for (int i = 0; i < 16; i++) rd(8'(i * 4), "R7 final", v0, v1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule